// File: doc/BRIEF.md
# Cascaded Maskable Interrupt Controller

This block collects interrupt requests from fifteen device lines and hands one of them at a time to a CPU as an 8-bit vector number. It has two eight-line stages. The secondary stage feeds one input of the primary stage, which is why fifteen lines remain usable and not sixteen. A rising edge on a device line latches that line as pending. The controller picks the lowest-numbered pending line that outranks everything currently in service. It raises its request output only while the CPU interrupt-enable flag is set.

The CPU acknowledges a delivered vector. On acknowledge the line moves from pending to in service, and the enable flag is saved and cleared. A return pulse restores the saved flag. The interrupt handler writes an end-of-interrupt code to the stage it was served from, which releases that stage's in-service line. A separate non-maskable input is delivered as vector 2 and ignores the enable flag.

Top module: `intc_cascade`

## Requirements
- R1: After reset, `int_req` is 0, `if_flag` is 0 and nothing is pending or in service.
- R2: When the flag is set, a rising edge on primary line n (n = 0,1,3..7) is requested with vector 0x20+n from the cycle after the edge is sampled.
- R3: A rising edge on secondary line n (n = 8..15) is requested with vector 0x28+(n-8).
- R4: No maskable line is requested while `if_flag` is 0. A `cpu_cli` pulse clears the flag and a `cpu_sti` pulse sets it.
- R5: A rising edge on `nmi_in` is requested with vector 0x02 whatever the value of `if_flag`. It takes precedence over any maskable line.
- R6: An acknowledge (`int_ack` while `int_req` is 1) saves `if_flag` and clears it. A `cpu_iret` pulse then restores the saved value.
- R7: An acknowledged line stays in service. While it is in service, it and every higher-numbered line in that stage are not requested. New edges on those lines stay pending.
- R8: Writing 0x20 to a stage's command port (`cmd_sel` 0 = primary, 1 = secondary) clears that stage's lowest-numbered in-service line. Any other written value has no effect.
- R9: A pending line with a lower number than every in-service line of its stage is requested, and so preempts the handler in progress.
- R10: A secondary line needs an end-of-interrupt on both stages. Until the primary one is written, all secondary lines stay blocked.
- R11: Bit 2 of `dev_req` is the cascade input and has no effect.
- R12: Among several pending lines, the lowest-numbered one is requested first.
- R13: Requests are edge-triggered. A line held high after it is serviced does not request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 16 | Device lines; bits 0..7 primary, 8..15 secondary, bit 2 unused |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| cpu_sti | input | 1 | Pulse: set the interrupt-enable flag |
| cpu_cli | input | 1 | Pulse: clear the interrupt-enable flag |
| cpu_iret | input | 1 | Pulse: restore the flag saved at acknowledge |
| int_ack | input | 1 | CPU accepts the vector shown this cycle |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_sel | input | 1 | Command port target: 0 primary, 1 secondary |
| cmd_data | input | 8 | Command byte; 0x20 is end-of-interrupt |
| int_req | output | 1 | Interrupt request to the CPU |
| int_vec | output | 8 | Vector number of the current request |
| if_flag | output | 1 | Current interrupt-enable flag |

## Verification
Several lines are raised together while the flag is clear. This separates a correct lowest-number-first order from one that follows arrival order or the highest number. Requests land on an in-service line, on a lower-numbered line and on a higher-numbered line. This separates blocking by priority from blocking only the line itself, and shows preemption. Secondary requests are given an end-of-interrupt on one stage and then on both, which shows whether the cascade input stays held. Non-maskable edges arrive with the flag both clear and set, and a held-high line is serviced and left high, which separates edge latching from level sensing.

// File: rtl/intc_pkg.sv
// Package for the cascaded interrupt controller.
// Holds the stage-select encoding and the vector composition rule.
// Assumes 8-bit vectors and a primary stage whose chained input
// carries the secondary stage's request.
package intc_pkg;

    typedef enum logic {
        STG_PRIMARY   = 1'b0,
        STG_SECONDARY = 1'b1
    } stage_sel_e;

    // Build the vector for a maskable delivery from the stage indices.
    function automatic logic [7:0] compose_vec(
        input logic [7:0] prim_base,
        input logic [7:0] sec_base,
        input int         chain_line,
        input int         prim_idx,
        input int         sec_idx
    );
        if (prim_idx == chain_line)
            return sec_base + 8'(sec_idx);
        else
            return prim_base + 8'(prim_idx);
    endfunction

endpackage

// File: rtl/intc_stage.sv
// One request stage of the controller: per-line edge latches, an
// in-service register and the priority resolver.
// Assumes the caller raises ack_i only while cand_valid_o is 1 and
// eoi_i for one cycle per end-of-interrupt command. When HAS_CHAIN
// is set, line CHAIN_IDX is replaced by the level chain_i
// (the request of a lower stage), which is never latched.
module intc_stage #(
    parameter int LINES     = 8,
    parameter bit HAS_CHAIN = 1'b0,
    parameter int CHAIN_IDX = 2,
    parameter int IDXW      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_i,
    input  logic             chain_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             cand_valid_o,
    output logic [IDXW-1:0]  cand_idx_o,
    output logic [LINES-1:0] isr_o
);

    localparam logic [LINES-1:0] CHAIN_MASK =
        HAS_CHAIN ? (LINES'(1) << CHAIN_IDX) : '0;

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] isr_q;
    logic [LINES-1:0] eff_pend;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] ack_mask;
    logic [LINES-1:0] eoi_mask;
    int               hi_isr;

    // Pending view: latched edges plus the chained level, if any.
    assign eff_pend = (pend_q & ~CHAIN_MASK) | ({LINES{chain_i}} & CHAIN_MASK);
    // New rising edges on real device lines.
    assign rise     = req_i & ~prev_q & ~CHAIN_MASK;
    // Line granted this cycle.
    assign ack_mask = ack_i ? (LINES'(1) << cand_idx_o) : '0;
    // Lowest-numbered in-service line released by an end-of-interrupt.
    assign eoi_mask = eoi_i ? (isr_q & (~isr_q + LINES'(1))) : '0;

    // Find the most urgent in-service line (LINES when none).
    always_comb begin
        hi_isr = LINES;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (isr_q[i]) hi_isr = i;
        end
    end

    // Pick the lowest pending line that outranks everything in service.
    always_comb begin
        cand_valid_o = 1'b0;
        cand_idx_o   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (eff_pend[i] && (i < hi_isr)) begin
                cand_valid_o = 1'b1;
                cand_idx_o   = IDXW'(i);
            end
        end
    end

    // Edge history, pending and in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            isr_q  <= '0;
        end else begin
            prev_q <= req_i;
            pend_q <= (pend_q & ~ack_mask) | rise;
            isr_q  <= (isr_q & ~eoi_mask) | ack_mask;
        end
    end

    assign isr_o = isr_q;

    // R2: a candidate is always something actually pending.
    p_cand_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid_o |-> eff_pend[cand_idx_o]);

    // R7: a line already in service is never offered again.
    p_cand_not_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid_o |-> !isr_q[cand_idx_o]);

    // R7: the granted line is in service on the next cycle.
    p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> isr_q[$past(cand_idx_o)]);

    // R8: an end-of-interrupt releases exactly one in-service line.
    p_eoi_releases_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && (|isr_q)) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))));

endmodule

// File: rtl/intc_cpuflag.sv
// Models the CPU interrupt-enable flag as seen by the controller.
// Assumes single-cycle pulses. Priority: acknowledge, then return,
// then clear, then set. Only one saved copy is kept, so a nested
// acknowledge overwrites the copy from the outer one.
module intc_cpuflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic ret_i,
    output logic flag_o
);

    logic flag_q;
    logic saved_q;

    // Flag update and save-on-acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            saved_q <= 1'b0;
        end else if (ack_i) begin
            saved_q <= flag_q;
            flag_q  <= 1'b0;
        end else if (ret_i) begin
            flag_q  <= saved_q;
        end else if (clr_i) begin
            flag_q  <= 1'b0;
        end else if (set_i) begin
            flag_q  <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R6: acknowledge always masks.
    p_ack_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !flag_q);

    // R6: a return brings back the value saved before it.
    p_ret_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !ack_i) |=> (flag_q == $past(saved_q)));

endmodule

// File: rtl/intc_cascade.sv
// Top of the cascaded controller: two stages, the non-maskable latch,
// the enable flag and the command port decode.
// Assumes int_ack is asserted by the CPU for one cycle per accepted
// vector. An ack while int_req is 0 is ignored.
module intc_cascade #(
    parameter int         STAGE_LINES = 8,
    parameter int         CHAIN_LINE  = 2,
    parameter logic [7:0] PRIM_BASE   = 8'h20,
    parameter logic [7:0] SEC_BASE    = 8'h28,
    parameter logic [7:0] NMI_VEC     = 8'h02,
    parameter logic [7:0] EOI_CODE    = 8'h20,
    parameter int         NLINES      = 2 * STAGE_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] dev_req,
    input  logic              nmi_in,
    input  logic              cpu_sti,
    input  logic              cpu_cli,
    input  logic              cpu_iret,
    input  logic              int_ack,
    input  logic              cmd_wr,
    input  logic              cmd_sel,
    input  logic [7:0]        cmd_data,
    output logic              int_req,
    output logic [7:0]        int_vec,
    output logic              if_flag
);
    import intc_pkg::*;

    localparam int IDXW = $clog2(STAGE_LINES);

    logic                   nmi_prev_q;
    logic                   nmi_pend_q;
    logic                   nmi_edge;
    logic                   ack_ok;
    logic                   prim_ack;
    logic                   sec_ack;
    logic                   eoi_prim;
    logic                   eoi_sec;
    logic                   prim_valid;
    logic                   sec_valid;
    logic [IDXW-1:0]        prim_idx;
    logic [IDXW-1:0]        sec_idx;
    logic [STAGE_LINES-1:0] prim_isr;
    logic [STAGE_LINES-1:0] sec_isr;
    stage_sel_e             sel;

    assign sel      = stage_sel_e'(cmd_sel);
    // Decode end-of-interrupt writes per stage.
    assign eoi_prim = cmd_wr && (sel == STG_PRIMARY)   && (cmd_data == EOI_CODE);
    assign eoi_sec  = cmd_wr && (sel == STG_SECONDARY) && (cmd_data == EOI_CODE);

    assign nmi_edge = nmi_in && !nmi_prev_q;
    assign ack_ok   = int_ack && int_req;
    // Maskable grant only when the non-maskable request is not the one shown.
    assign prim_ack = ack_ok && !nmi_pend_q;
    assign sec_ack  = prim_ack && (int'(prim_idx) == CHAIN_LINE);

    intc_stage #(
        .LINES     (STAGE_LINES),
        .HAS_CHAIN (1'b0),
        .CHAIN_IDX (CHAIN_LINE)
    ) u_sec (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (dev_req[NLINES-1:STAGE_LINES]),
        .chain_i      (1'b0),
        .ack_i        (sec_ack),
        .eoi_i        (eoi_sec),
        .cand_valid_o (sec_valid),
        .cand_idx_o   (sec_idx),
        .isr_o        (sec_isr)
    );

    intc_stage #(
        .LINES     (STAGE_LINES),
        .HAS_CHAIN (1'b1),
        .CHAIN_IDX (CHAIN_LINE)
    ) u_prim (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (dev_req[STAGE_LINES-1:0]),
        .chain_i      (sec_valid),
        .ack_i        (prim_ack),
        .eoi_i        (eoi_prim),
        .cand_valid_o (prim_valid),
        .cand_idx_o   (prim_idx),
        .isr_o        (prim_isr)
    );

    intc_cpuflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cpu_sti),
        .clr_i  (cpu_cli),
        .ack_i  (ack_ok),
        .ret_i  (cpu_iret),
        .flag_o (if_flag)
    );

    // Non-maskable edge latch; consumed by its own acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_in;
            if (nmi_edge)
                nmi_pend_q <= 1'b1;
            else if (ack_ok)
                nmi_pend_q <= 1'b0;
        end
    end

    // Request and vector presented to the CPU.
    always_comb begin
        int_req = nmi_pend_q || (if_flag && prim_valid);
        if (nmi_pend_q)
            int_vec = NMI_VEC;
        else
            int_vec = compose_vec(PRIM_BASE, SEC_BASE, CHAIN_LINE,
                                  int'(prim_idx), int'(sec_idx));
    end

    // R5: a non-maskable edge is shown as vector 2 on the next cycle.
    p_nmi_delivered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_edge && !ack_ok) |=> (int_req && int_vec == NMI_VEC));

    // R4: with the flag clear only the non-maskable source may request.
    p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_flag && int_req) |-> nmi_pend_q);

    // R10: a secondary line in service keeps the cascade input in service.
    p_cascade_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|sec_isr) |-> prim_isr[CHAIN_LINE]);

endmodule

// File: tb/sim_intc_cascade.sv
`timescale 1ns/1ps
module sim_intc_cascade;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_req = '0;
    logic        nmi_in = 1'b0;
    logic        cpu_sti = 1'b0;
    logic        cpu_cli = 1'b0;
    logic        cpu_iret = 1'b0;
    logic        int_ack = 1'b0;
    logic        cmd_wr = 1'b0;
    logic        cmd_sel = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        int_req;
    logic [7:0]  int_vec;
    logic        if_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    intc_cascade u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_in(nmi_in),
        .cpu_sti(cpu_sti), .cpu_cli(cpu_cli), .cpu_iret(cpu_iret),
        .int_ack(int_ack), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .int_req(int_req), .int_vec(int_vec),
        .if_flag(if_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Request expected with a given vector.
    task automatic want(input string tag, input int vec);
        chk(int_req == 1'b1, {tag, " req"}, int'(int_req), 1);
        chk(int_vec == vec[7:0], {tag, " vec"}, int'(int_vec), vec);
    endtask

    task automatic idle(input string tag);
        chk(int_req == 1'b0, {tag, " no req"}, int'(int_req), 0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        dev_req[n] = 1'b1; step(); dev_req[n] = 1'b0; step();
    endtask

    task automatic nmi_pulse();
        nmi_in = 1'b1; step(); nmi_in = 1'b0; step();
    endtask

    task automatic do_ack();  int_ack = 1'b1;  step(); int_ack = 1'b0;  endtask
    task automatic do_iret(); cpu_iret = 1'b1; step(); cpu_iret = 1'b0; endtask
    task automatic do_sti();  cpu_sti = 1'b1;  step(); cpu_sti = 1'b0;  endtask
    task automatic do_cli();  cpu_cli = 1'b1;  step(); cpu_cli = 1'b0;  endtask

    task automatic cmd(input bit s, input logic [7:0] d);
        cmd_wr = 1'b1; cmd_sel = s; cmd_data = d; step(); cmd_wr = 1'b0;
    endtask

    task automatic serve_prim(); do_ack(); do_iret(); cmd(1'b0, 8'h20); endtask
    task automatic serve_sec();  do_ack(); do_iret(); cmd(1'b1, 8'h20); cmd(1'b0, 8'h20); endtask

    task automatic t_reset();
        idle("R1 after reset");
        chk(if_flag == 1'b0, "R1 flag", int'(if_flag), 0);
    endtask

    task automatic t_mask();
        pulse(5);
        idle("R4 flag clear");
        do_sti();
        chk(if_flag == 1'b1, "R4 sti", int'(if_flag), 1);
        want("R2 line5", 8'h25);
        do_cli();
        idle("R4 after cli");
        do_sti();
        do_ack();
        chk(if_flag == 1'b0, "R6 ack clears", int'(if_flag), 0);
        idle("R6 after ack");
        do_iret();
        chk(if_flag == 1'b1, "R6 iret restores 1", int'(if_flag), 1);
        idle("R2 pending consumed");
        cmd(1'b0, 8'h20);
        pulse(5);
        want("R2 line5 again", 8'h25);
        serve_prim();
    endtask

    task automatic t_block();
        pulse(4);
        do_ack(); do_iret();
        pulse(4);
        idle("R7 same line blocked");
        pulse(6);
        idle("R7 lower priority blocked");
        cmd(1'b0, 8'h21);
        idle("R8 non-EOI value ignored");
        cmd(1'b1, 8'h20);
        idle("R8 other stage EOI no effect");
        cmd(1'b0, 8'h20);
        want("R7 held request delivered", 8'h24);
        serve_prim();
        want("R7 next pending", 8'h26);
        serve_prim();
        idle("R7 drained");
    endtask

    task automatic t_preempt();
        pulse(6);
        do_ack(); do_iret();
        pulse(1);
        want("R9 line1 preempts", 8'h21);
        do_ack(); do_iret();
        cmd(1'b0, 8'h20);
        pulse(7);
        idle("R8 EOI released line1 only");
        cmd(1'b0, 8'h20);
        want("R8 second EOI frees line6", 8'h27);
        serve_prim();
        idle("R9 drained");
    endtask

    task automatic t_prio();
        do_cli();
        dev_req[5] = 1'b1; dev_req[3] = 1'b1; dev_req[0] = 1'b1;
        step();
        dev_req = '0;
        step();
        do_sti();
        want("R12 first", 8'h20);
        serve_prim();
        want("R12 second", 8'h23);
        serve_prim();
        want("R12 third", 8'h25);
        serve_prim();
        idle("R12 drained");
    endtask

    task automatic t_secondary();
        pulse(11);
        want("R3 line11", 8'h2B);
        do_ack(); do_iret();
        pulse(9);
        idle("R10 secondary blocked");
        cmd(1'b1, 8'h20);
        idle("R10 one EOI not enough");
        cmd(1'b0, 8'h20);
        want("R10 after both EOIs", 8'h29);
        serve_sec();
        pulse(15);
        want("R3 line15", 8'h2F);
        serve_sec();
        idle("R3 drained");
    endtask

    task automatic t_chain();
        pulse(2);
        idle("R11 bit2 ignored");
    endtask

    task automatic t_nmi();
        do_cli();
        pulse(3);
        idle("R4 masked line3");
        nmi_pulse();
        want("R5 nmi flag clear", 8'h02);
        do_ack();
        idle("R5 nmi consumed");
        do_iret();
        chk(if_flag == 1'b0, "R6 iret restores 0", int'(if_flag), 0);
        do_sti();
        want("R5 maskable after nmi", 8'h23);
        nmi_pulse();
        want("R5 nmi over maskable", 8'h02);
        do_ack();
        idle("R5 masked after nmi ack");
        do_iret();
        want("R6 flag back, line3", 8'h23);
        serve_prim();
        idle("R5 drained");
    endtask

    task automatic t_level();
        dev_req[4] = 1'b1;
        step(); step();
        want("R13 level rise", 8'h24);
        serve_prim();
        step(); step();
        idle("R13 held high no repeat");
        dev_req[4] = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mask();
        t_block();
        t_preempt();
        t_prio();
        t_secondary();
        t_chain();
        t_nmi();
        t_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule